// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static RAM Read Controller

This block sits on the host side of a clocked pseudo-static RAM and fetches four 16-bit words per request as a synchronous burst. A request carries a word address. The controller lowers chip select and pulses the address-valid strobe for one clock with the address on the bus. It then enables the output drivers and both byte lanes, and it takes a data word on every rising edge where the memory's active-low ready line (`mem_wait_n`) is sampled high. Each word is handed to the host with a one-cycle valid strobe. A done pulse marks the end of the burst.

When another request is waiting as the last word arrives, the controller can start the next burst without raising chip select. It does this by issuing a fresh address-valid pulse and address. A budget counter keeps any single chip-select-low period within a time cap, which a parameter converts from nanoseconds into clocks. A chained burst is started only if a full burst still fits in the remaining budget. Otherwise chip select goes high first, and the waiting request then opens a new cycle. If the memory stalls long enough that the cap is reached inside a burst, chip select is raised at the cap and the burst is closed with a done pulse.

Top module: `psram_burst_rd`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `mem_cs_n`, `mem_adv_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, and `rvalid`, `done` and `busy` are 0.
- R2: Each burst starts with exactly one cycle in which `mem_adv_n` is 0, `mem_cs_n` is 0 and `mem_addr` carries the accepted request address. Chip select stays low from that cycle until the burst ends.
- R3: `mem_adv_n` is never driven low after a burst's address cycle until all four words of that burst have been taken or the burst has been cut off by the time cap.
- R4: `mem_oe_n` and `mem_be_n` stay inactive (1 and 2'b11) in the address cycle and in the cycle that follows it. They become active (0 and 2'b00) one clock after the memory's burst start edge.
- R5: A word is taken only on a rising edge where chip select is low, output enable is active and `mem_wait_n` is 1. `rdata` holds that word and `rvalid` is 1 in the following cycle. Edges with `mem_wait_n` at 0 delay the remaining words and do not lose any.
- R6: A burst delivers exactly four words. `done` is 1 in the same cycle as the fourth `rvalid`.
- R7: While chip select is high, `mem_wait_n` is ignored: no `rvalid` is produced whatever its level.
- R8: Chaining. The current cycle is cycle n of the chip-select-low period. If a request is presented in the cycle the fourth word is taken, and n + LAT + 4 is at most the cap in clocks, then the next cycle is that request's address cycle and chip select stays low.
- R9: If a request is waiting but the check in R8 fails, chip select goes high for at least one cycle, and the request then starts a new chip-select-low period.
- R10: `mem_cs_n` is never low for more than CAP = TBC_NS*1000/CLK_PS consecutive cycles. If the cap is reached inside a burst, chip select rises right after cycle CAP and `done` pulses in that first high cycle.
- R11: A request is taken on the edge where `req` is 1 and `busy` is 0. `busy` is low only while idle, or in a last-word cycle that can chain. A request held while `busy` is 1 is served later, and requests are served in order.
- R12: Whenever `mem_cs_n` is 1, `mem_oe_n` is 1 and `mem_be_n` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the memory's burst clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, held until taken |
| addr | input | AW | Word address of the request |
| busy | output | 1 | High when a request would not be taken this cycle |
| rdata | output | DW | Delivered data word |
| rvalid | output | 1 | `rdata` valid this cycle |
| done | output | 1 | Burst finished or cut off |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Upper and lower byte enables, active low |
| mem_addr | output | AW | Memory address bus |
| mem_wait_n | input | 1 | Memory ready line, low means data not yet available |
| mem_dq | input | DW | Memory data bus |

## Verification
The main read path is tried in four ways. A lone request checks the basic timing of address, enables and data. A pair of waiting requests must chain under one chip-select period. A triple must chain once and then be forced to reopen chip select, which separates the budget rule from plain chaining. A mid-burst stall of a few cycles shows that captures follow the ready line and not a fixed latency. A stall longer than the cap must end the period at exactly the cap with a done pulse, and a request that arrives while the controller is busy must still be served after the request in progress.

// File: rtl/psram_rd_pkg.sv
`timescale 1ns/1ps
package psram_rd_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ADDR = 2'd1,
    PS_DATA = 2'd2
  } pst_e;

  // Number of whole clocks that fit inside the chip-select-low time cap.
  function automatic int cs_limit(input int tbc_ns, input int clk_ps);
    return (tbc_ns * 1000) / clk_ps;
  endfunction

  // A further burst takes lat + words low cycles after the current one.
  function automatic logic chain_fits(input int cycle_now, input int lat,
                                      input int words, input int cap);
    return (cycle_now + lat + words) <= cap;
  endfunction

endpackage

// File: rtl/psram_cs_budget.sv
`timescale 1ns/1ps
module psram_cs_budget import psram_rd_pkg::*; #(
  parameter int CS_MAX = 312,
  parameter int LAT    = 5,
  parameter int WORDS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic at_limit,
  output logic chain_ok
);
  localparam int CW = $clog2(CS_MAX + 1);

  // Number of completed low cycles before the current one.
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      low_cnt <= '0;
    else if (cs_n)   low_cnt <= '0;
    else             low_cnt <= low_cnt + 1'b1;
  end

  assign at_limit = !cs_n && (32'(low_cnt) >= CS_MAX - 1);
  assign chain_ok = chain_fits(32'(low_cnt) + 1, LAT, WORDS, CS_MAX);

endmodule

// File: rtl/psram_capture.sv
`timescale 1ns/1ps
module psram_capture #(
  parameter int DW    = 16,
  parameter int WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_start,
  input  logic          cap_fire,
  input  logic          abort_fire,
  input  logic [DW-1:0] dq,
  output logic          last_word,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          done
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [IW-1:0] widx;

  assign last_word = cap_fire && (widx == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           widx <= '0;
    else if (burst_start) widx <= '0;
    else if (cap_fire)    widx <= widx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (cap_fire) rdata <= dq;
      rvalid <= cap_fire;
      done   <= last_word || abort_fire;
    end
  end

endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq import psram_rd_pkg::*; #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          last_word,
  input  logic          at_limit,
  input  logic          chain_ok,
  output pst_e          state,
  output logic          cs_n,
  output logic          adv_n,
  output logic          oe_n,
  output logic [AW-1:0] maddr,
  output logic          busy
);
  pst_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_IDLE: if (req) nxt = PS_ADDR;
      PS_ADDR: nxt = at_limit ? PS_IDLE : PS_DATA;
      PS_DATA: begin
        if (at_limit)       nxt = PS_IDLE;
        else if (last_word) nxt = (req && chain_ok) ? PS_ADDR : PS_IDLE;
      end
      default: nxt = PS_IDLE;
    endcase
  end

  assign busy = !((state == PS_IDLE) ||
                  ((state == PS_DATA) && !at_limit && last_word && chain_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      cs_n  <= 1'b1;
      adv_n <= 1'b1;
      oe_n  <= 1'b1;
      maddr <= '0;
    end else begin
      state <= nxt;
      cs_n  <= (nxt == PS_IDLE);
      adv_n <= (nxt != PS_ADDR);
      oe_n  <= !((nxt == PS_DATA) && (state == PS_DATA));
      if (nxt == PS_ADDR) maddr <= addr;
    end
  end

endmodule

// File: rtl/psram_burst_rd.sv
`timescale 1ns/1ps
module psram_burst_rd import psram_rd_pkg::*; #(
  parameter int AW     = 21,
  parameter int DW     = 16,
  parameter int WORDS  = 4,
  parameter int LAT    = 5,
  parameter int CLK_PS = 8000,
  parameter int TBC_NS = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          done,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic [1:0]    mem_be_n,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_wait_n,
  input  logic [DW-1:0] mem_dq
);
  localparam int CS_MAX = cs_limit(TBC_NS, CLK_PS);

  // Named internal events, also observed by the checker.
  pst_e state;
  logic burst_start;
  logic cap_fire;
  logic abort_fire;
  logic last_word;
  logic at_limit;
  logic chain_ok;

  assign burst_start = (state == PS_ADDR);
  assign cap_fire    = (state == PS_DATA) && !mem_oe_n && mem_wait_n;
  assign abort_fire  = (state != PS_IDLE) && at_limit;
  assign mem_be_n    = {2{mem_oe_n}};

  psram_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .addr      (addr),
    .last_word (last_word),
    .at_limit  (at_limit),
    .chain_ok  (chain_ok),
    .state     (state),
    .cs_n      (mem_cs_n),
    .adv_n     (mem_adv_n),
    .oe_n      (mem_oe_n),
    .maddr     (mem_addr),
    .busy      (busy)
  );

  psram_capture #(.DW(DW), .WORDS(WORDS)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .cap_fire    (cap_fire),
    .abort_fire  (abort_fire),
    .dq          (mem_dq),
    .last_word   (last_word),
    .rdata       (rdata),
    .rvalid      (rvalid),
    .done        (done)
  );

  psram_cs_budget #(.CS_MAX(CS_MAX), .LAT(LAT), .WORDS(WORDS)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (mem_cs_n),
    .at_limit (at_limit),
    .chain_ok (chain_ok)
  );

endmodule

// File: rtl/psram_rd_chk.sv
`timescale 1ns/1ps
module psram_rd_chk #(
  parameter int CS_MAX = 312,
  parameter int WORDS  = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       adv_n,
  input logic       oe_n,
  input logic [1:0] be_n,
  input logic       wait_n,
  input logic       rvalid,
  input logic       done
);
  int   low_cnt;
  int   rv_cnt;
  logic in_burst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= 0;
      rv_cnt   <= 0;
      in_burst <= 1'b0;
    end else begin
      low_cnt <= cs_n ? 0 : low_cnt + 1;
      if (!adv_n)      rv_cnt <= 0;
      else if (rvalid) rv_cnt <= rv_cnt + 1;
      if (!adv_n)      in_burst <= 1'b1;
      else if (done)   in_burst <= 1'b0;
    end
  end

  // R2
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> adv_n);

  // R2
  adv_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !cs_n);

  // R3
  adv_mid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !done) |-> adv_n);

  // R4
  oe_addr_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> (oe_n && be_n == 2'b11));

  // R4
  oe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> (oe_n && be_n == 2'b11));

  // R5
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(wait_n && !oe_n && !cs_n));

  // R6
  word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rv_cnt < WORDS));

  // R6
  done_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rvalid) |-> (rv_cnt == WORDS - 1));

  // R10
  cs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (low_cnt < CS_MAX));

  // R12
  oe_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (oe_n && be_n == 2'b11));

endmodule

bind psram_burst_rd psram_rd_chk #(.CS_MAX(CS_MAX), .WORDS(WORDS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (mem_cs_n),
  .adv_n  (mem_adv_n),
  .oe_n   (mem_oe_n),
  .be_n   (mem_be_n),
  .wait_n (mem_wait_n),
  .rvalid (rvalid),
  .done   (done)
);

// File: tb/sim_psram_burst_rd.sv
`timescale 1ns/1ps
module sim_psram_burst_rd;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int WORDS = 4;
  localparam int LAT = 5;
  localparam int CLK_PS = 8000;
  localparam int TBC_NS = 200;
  localparam int CAP = (TBC_NS * 1000) / CLK_PS;   // 25 clocks
  localparam int BURST = LAT + WORDS;              // low cycles per burst

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy, rvalid, done, cs_n, adv_n, oe_n;
  logic [DW-1:0] rdata;
  logic [1:0] be_n;
  logic [AW-1:0] maddr;
  logic m_wait = 1'b1;
  logic [DW-1:0] m_dq = '0;

  always #4 clk = ~clk;

  psram_burst_rd #(.AW(AW), .DW(DW), .WORDS(WORDS), .LAT(LAT),
                   .CLK_PS(CLK_PS), .TBC_NS(TBC_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
    .rdata(rdata), .rvalid(rvalid), .done(done),
    .mem_cs_n(cs_n), .mem_adv_n(adv_n), .mem_oe_n(oe_n), .mem_be_n(be_n),
    .mem_addr(maddr), .mem_wait_n(m_wait), .mem_dq(m_dq));

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a, input int w);
    return DW'(a * 7 + w * 16'h1111) ^ 16'h5A5A;
  endfunction

  // Host side and memory model state
  logic [AW-1:0] hq[$];
  logic [AW-1:0] acc_q[$];
  int stall = 0;
  bit busy_s, adv_s;
  logic [AW-1:0] maddr_s;
  bit mact = 0;
  int mp = 0, mnext = 0, mwidx = 0;
  logic [AW-1:0] mbase = '0;
  bit pres = 0, plast = 0;
  logic [DW-1:0] pword = '0;
  bit exp_rv = 0, exp_done = 0;
  logic [DW-1:0] exp_rd = '0;
  int low_run = 0, adv_in_run = 0;
  int runs_adv[$];
  int runs_len[$];

  // Memory and host behaviour, updated just after each rising edge.
  always @(posedge clk) begin
    exp_rv   = pres && m_wait;
    exp_rd   = pword;
    exp_done = pres && m_wait && plast;
    if (!rst_n) begin
      mact = 0;
    end else begin
      if (adv_s) begin
        if (acc_q.size() > 0) begin
          chk(maddr_s == acc_q[0], "R11", int'(maddr_s), int'(acc_q[0]));
          void'(acc_q.pop_front());
        end else chk(0, "R2", int'(maddr_s), -1);
        mact = 1; mp = 0; mnext = LAT; mwidx = 0; mbase = maddr_s;
      end else if (mact) begin
        mp++;
      end
      if (req && !busy_s && hq.size() > 0) begin
        acc_q.push_back(hq[0]);
        void'(hq.pop_front());
      end
    end
    #1;
    if (cs_n && mact && mwidx < WORDS) begin
      exp_done = 1;   // burst cut off by the time cap
      mact = 0;
    end
    pres = 0; plast = 0;
    if (mact && cs_n == 1'b0 && mp + 1 == mnext && mwidx < WORDS) begin
      pres  = 1;
      plast = (mwidx == WORDS - 1);
      pword = word_of(mbase, mwidx);
      mnext = mp + 2 + ((mwidx == 0) ? stall : 0);
      mwidx++;
      if (mwidx == WORDS) mact = 0;
      m_wait = 1'b1;
      m_dq   = pword;
    end else begin
      m_wait = cs_n ? 1'b1 : 1'b0;   // high level while deselected must be ignored
      m_dq   = 16'hDEAD;
    end
    req  = (hq.size() > 0);
    addr = (hq.size() > 0) ? hq[0] : '0;
  end

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rvalid == exp_rv, "R5", rvalid, exp_rv);
      if (exp_rv) chk(rdata == exp_rd, "R5", rdata, exp_rd);
      chk(done == exp_done, "R6", done, exp_done);
      if (cs_n) chk(oe_n && be_n == 2'b11, "R12", {oe_n, be_n}, 3'b111);
      if (!adv_n) begin
        chk(oe_n && be_n == 2'b11, "R4", {oe_n, be_n}, 3'b111);
        chk(!cs_n, "R2", cs_n, 0);
        chk(!(mact && mwidx < WORDS), "R3", mwidx, WORDS);
      end
      if (mact && mp == 0) chk(oe_n, "R4", oe_n, 1);
      if (!cs_n) begin
        low_run++;
        if (!adv_n) adv_in_run++;
        chk(low_run <= CAP, "R10", low_run, CAP);
      end else if (low_run > 0) begin
        runs_len.push_back(low_run);
        runs_adv.push_back(adv_in_run);
        low_run = 0; adv_in_run = 0;
      end
    end
    busy_s  = busy;
    adv_s   = !adv_n && !cs_n;
    maddr_s = maddr;
  end

  task automatic wait_idle();
    do @(negedge clk); while (hq.size() != 0 || acc_q.size() != 0 || !cs_n || mact);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(8 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cs_n && adv_n && oe_n, "R1", {cs_n, adv_n, oe_n}, 3'b111);
    chk(be_n == 2'b11, "R1", be_n, 2'b11);
    chk(!rvalid && !done && !busy, "R1", {rvalid, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && !rvalid, "R1", {cs_n, busy, rvalid}, 3'b100);
    // R7: ready line high while deselected gives no data
    repeat (6) begin
      @(negedge clk);
      chk(!rvalid && m_wait, "R7", {rvalid, m_wait}, 2'b01);
    end

    // Lone request
    hq.push_back(21'h00123);
    wait_idle();
    chk(runs_adv[$] == 1, "R2", runs_adv[$], 1);
    chk(runs_len[$] == BURST, "R6", runs_len[$], BURST);

    // Two waiting requests chain in one low period
    hq.push_back(21'h01000); hq.push_back(21'h01004);
    wait_idle();
    chk(runs_adv[$] == 2, "R8", runs_adv[$], 2);
    chk(runs_len[$] == 2 * BURST, "R8", runs_len[$], 2 * BURST);

    // Three: third burst would overrun the cap, so chip select reopens
    n0 = runs_adv.size();
    hq.push_back(21'h02000); hq.push_back(21'h02010); hq.push_back(21'h02020);
    wait_idle();
    chk(runs_adv.size() == n0 + 2, "R9", runs_adv.size() - n0, 2);
    chk(runs_adv[n0] == 2, "R9", runs_adv[n0], 2);
    chk(runs_adv[$] == 1, "R9", runs_adv[$], 1);

    // Mid-burst stall of three edges
    stall = 3;
    hq.push_back(21'h0ABCD);
    wait_idle();
    chk(runs_len[$] == BURST + 3, "R5", runs_len[$], BURST + 3);

    // Stall longer than the cap: cut off at exactly CAP low cycles
    stall = 40;
    hq.push_back(21'h15555);
    wait_idle();
    chk(runs_len[$] == CAP, "R10", runs_len[$], CAP);
    stall = 0;

    // Request raised while busy is served afterwards
    hq.push_back(21'h03300);
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R11", busy, 1);
    hq.push_back(21'h03340);
    wait_idle();
    chk(runs_adv[$] == 2, "R11", runs_adv[$], 2);

    report();
    $finish;
  end

endmodule